// File: doc/BRIEF.md
# Two-by-two drop/deflect switching node

This block is one self-routing switching element for a slotted, bufferless multistage network. Each of its two inputs carries a message made of a frame bit (message present), a header of address bits and a payload. At the start of a slot the node looks at the frame bit and at one chosen address bit of each input, and picks one of six connection states. It holds that state for the whole slot, so the payload that follows the header takes the same path. An acknowledgement raised by the next stage on an output travels back through the same connection to the input that feeds it. When the slot ends the node returns to idle.

Two inputs may ask for the same output. A build-time mode decides what happens to the losing message. In routing mode the loser is dropped, and the winner is sent alone through one of four single-input states. In deflecting mode the loser takes the output it did not ask for, so no message is lost. The winner is picked by a build-time policy: a toggle that alternates between the inputs, a fixed preference for input 0, or a pseudo-random bit from an LFSR. The node adds nothing to the message and uses no signal from any other node.

Top module: `swnode_top`

## Requirements
- R1: While reset is high and in the cycle after it falls, `state_o` is 0, every output frame, header and payload is 0, and both input acknowledgements are 0.
- R2: `state_o` encodes the connection: 0 idle, 1 straight (in0 to out0, in1 to out1), 2 interchange (in0 to out1, in1 to out0), 3 input 0 alone to out0, 4 input 0 alone to out1, 5 input 1 alone to out1, 6 input 1 alone to out0. The value 7 never appears. An output with no source drives all zeros.
- R3: Address bit `ADDR_SEL` of a header requests out0 when 0 and out1 when 1. A single valid input always gets state 3/4 (input 0) or 5/6 (input 1) toward the output it asked for. Two valid inputs that ask for different outputs get state 1 or 2. Only these states drive both output frames at once.
- R4: In routing mode (`DEFLECT` = 0), when two valid inputs ask for the same output, only the winner is forwarded, to the output it asked for. The other output stays all zeros.
- R5: In deflecting mode (`DEFLECT` = 1), two valid inputs always give state 1 or 2. The winner reaches the output it asked for and the loser the other one.
- R6: With the alternating policy, input 0 wins the first contention after reset. The winner then switches after every contended slot. Slots without contention leave the next winner unchanged.
- R7: With the fixed policy, input 0 wins every contention.
- R8: With the random policy, each contention result is a legal state for one of the two winners, and over many contentions each input wins at least once.
- R9: The state is loaded on a cycle in which `slot_start` is high and is visible from the next cycle. It then stays unchanged whatever the inputs do until a cycle in which `slot_end` is high and `slot_start` is low, after which it is 0. When both strobes are high, the new slot is loaded.
- R10: `in0_ack` and `in1_ack` equal `out0_ack`/`out1_ack` of the output their input is connected to in the current state, and are 0 otherwise.
- R11: Header bits other than `ADDR_SEL` have no effect on the state and pass to the output unchanged along with the payload.
- R12: A slot that starts with neither frame valid leaves the node in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_start | input | 1 | Load a new state from the current headers |
| slot_end | input | 1 | Return to idle |
| in0_frame | input | 1 | Input 0 message present |
| in0_hdr | input | ADDR_W | Input 0 address bits |
| in0_data | input | DATA_W | Input 0 payload |
| in1_frame | input | 1 | Input 1 message present |
| in1_hdr | input | ADDR_W | Input 1 address bits |
| in1_data | input | DATA_W | Input 1 payload |
| out0_ack | input | 1 | Acknowledgement arriving back on output 0 |
| out1_ack | input | 1 | Acknowledgement arriving back on output 1 |
| out0_frame | output | 1 | Output 0 message present |
| out0_hdr | output | ADDR_W | Output 0 address bits |
| out0_data | output | DATA_W | Output 0 payload |
| out1_frame | output | 1 | Output 1 message present |
| out1_hdr | output | ADDR_W | Output 1 address bits |
| out1_data | output | DATA_W | Output 1 payload |
| in0_ack | output | 1 | Acknowledgement returned to input 0 |
| in1_ack | output | 1 | Acknowledgement returned to input 1 |
| state_o | output | 3 | Current connection state |

## Verification
The bench builds three copies with a 3-bit header, `ADDR_SEL` = 1 and a 16-bit payload, all fed the same stimulus. The first uses routing mode with alternating priority and can reach all six states, including both drop directions for each input. The second uses deflecting mode with fixed priority, which shows that a contention never loses a message. The third uses routing mode with the random policy, which shows that both inputs win at least once. Header bit 1 is the selected bit, so changing bits 0 and 2 shows that those bits are ignored for the decision and still pass through to the output.

// File: rtl/swnode_pkg.sv
package swnode_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_STRAIGHT = 3'd1,
        ST_CROSS    = 3'd2,
        ST_UP_THRU  = 3'd3,
        ST_UP_SWAP  = 3'd4,
        ST_LO_THRU  = 3'd5,
        ST_LO_SWAP  = 3'd6
    } sw_state_e;

    typedef enum logic [1:0] {
        ARB_ALTERNATE = 2'd0,
        ARB_FIXED     = 2'd1,
        ARB_RANDOM    = 2'd2
    } arb_kind_e;

    // Which input, if any, feeds a given output in a given state.
    typedef struct packed {
        logic en;
        logic src;
    } route_t;

    function automatic route_t out_route(sw_state_e s, logic port);
        route_t r;
        r = '0;
        if (!port) begin
            case (s)
                ST_STRAIGHT, ST_UP_THRU: r = '{en: 1'b1, src: 1'b0};
                ST_CROSS, ST_LO_SWAP:    r = '{en: 1'b1, src: 1'b1};
                default:                 r = '0;
            endcase
        end else begin
            case (s)
                ST_STRAIGHT, ST_LO_THRU: r = '{en: 1'b1, src: 1'b1};
                ST_CROSS, ST_UP_SWAP:    r = '{en: 1'b1, src: 1'b0};
                default:                 r = '0;
            endcase
        end
        return r;
    endfunction

    // Single-input state that sends input `who` to output `dst`.
    function automatic sw_state_e solo_state(logic who, logic dst);
        if (!who) return dst ? ST_UP_SWAP : ST_UP_THRU;
        return dst ? ST_LO_THRU : ST_LO_SWAP;
    endfunction

    // Two-input state that sends input `who` to output `dst`.
    function automatic sw_state_e pair_state(logic who, logic dst);
        return (who ^ dst) ? ST_CROSS : ST_STRAIGHT;
    endfunction

endpackage

// File: rtl/swnode_arbiter.sv
module swnode_arbiter
    import swnode_pkg::*;
#(
    parameter arb_kind_e           ARB       = ARB_ALTERNATE,
    parameter int                  LFSR_W    = 8,
    parameter logic [LFSR_W-1:0]   LFSR_TAPS = 8'hB8,
    parameter logic [LFSR_W-1:0]   LFSR_SEED = 8'h5A
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic contend,
    output logic win1
);

    generate
        if (ARB == ARB_ALTERNATE) begin : g_alt
            logic turn_q;
            always_ff @(posedge clk) begin
                if (rst)                 turn_q <= 1'b0;
                else if (take && contend) turn_q <= ~turn_q;
            end
            assign win1 = turn_q;
        end else if (ARB == ARB_RANDOM) begin : g_rnd
            logic [LFSR_W-1:0] lfsr_q;
            logic              fb;
            assign fb = ^(lfsr_q & LFSR_TAPS);
            always_ff @(posedge clk) begin
                if (rst) lfsr_q <= LFSR_SEED;
                else     lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
            end
            assign win1 = lfsr_q[0];
        end else begin : g_fix
            assign win1 = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/swnode_decide.sv
module swnode_decide
    import swnode_pkg::*;
#(
    parameter bit DEFLECT = 1'b0
) (
    input  logic      f0,
    input  logic      a0,
    input  logic      f1,
    input  logic      a1,
    input  logic      win1,
    output logic      contend,
    output sw_state_e next_state
);

    logic      win_dst;
    sw_state_e contend_state;

    assign contend = f0 && f1 && (a0 == a1);
    assign win_dst = win1 ? a1 : a0;

    generate
        if (DEFLECT) begin : g_defl
            assign contend_state = pair_state(win1, win_dst);
        end else begin : g_drop
            assign contend_state = solo_state(win1, win_dst);
        end
    endgenerate

    always_comb begin
        if (!f0 && !f1)      next_state = ST_IDLE;
        else if (!f1)        next_state = solo_state(1'b0, a0);
        else if (!f0)        next_state = solo_state(1'b1, a1);
        else if (!contend)   next_state = pair_state(1'b0, a0);
        else                 next_state = contend_state;
    end

endmodule

// File: rtl/swnode_xbar.sv
module swnode_xbar
    import swnode_pkg::*;
#(
    parameter int MSG_W = 20
) (
    input  sw_state_e        state,
    input  logic [MSG_W-1:0] in_msg  [2],
    input  logic             out_ack [2],
    output logic [MSG_W-1:0] out_msg [2],
    output logic             in_ack  [2]
);

    route_t rt [2];

    generate
        for (genvar p = 0; p < 2; p++) begin : g_out
            assign rt[p]      = out_route(state, p[0]);
            assign out_msg[p] = rt[p].en ? in_msg[rt[p].src] : '0;
        end
        for (genvar i = 0; i < 2; i++) begin : g_back
            assign in_ack[i] = (rt[0].en && (rt[0].src == i[0]) && out_ack[0])
                             | (rt[1].en && (rt[1].src == i[0]) && out_ack[1]);
        end
    endgenerate

endmodule

// File: rtl/swnode_top.sv
module swnode_top
    import swnode_pkg::*;
#(
    parameter int                ADDR_W    = 3,
    parameter int                ADDR_SEL  = 1,
    parameter int                DATA_W    = 16,
    parameter bit                DEFLECT   = 1'b0,
    parameter arb_kind_e         ARB       = ARB_ALTERNATE,
    parameter int                LFSR_W    = 8,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_start,
    input  logic              slot_end,
    input  logic              in0_frame,
    input  logic [ADDR_W-1:0] in0_hdr,
    input  logic [DATA_W-1:0] in0_data,
    input  logic              in1_frame,
    input  logic [ADDR_W-1:0] in1_hdr,
    input  logic [DATA_W-1:0] in1_data,
    input  logic              out0_ack,
    input  logic              out1_ack,
    output logic              out0_frame,
    output logic [ADDR_W-1:0] out0_hdr,
    output logic [DATA_W-1:0] out0_data,
    output logic              out1_frame,
    output logic [ADDR_W-1:0] out1_hdr,
    output logic [DATA_W-1:0] out1_data,
    output logic              in0_ack,
    output logic              in1_ack,
    output logic [2:0]        state_o
);

    localparam int MSG_W = 1 + ADDR_W + DATA_W;

    sw_state_e        state_q;
    sw_state_e        state_d;
    logic             contend;
    logic             win1;
    logic [MSG_W-1:0] in_msg  [2];
    logic [MSG_W-1:0] out_msg [2];
    logic             out_ack [2];
    logic             in_ack  [2];

    swnode_arbiter #(
        .ARB       (ARB),
        .LFSR_W    (LFSR_W),
        .LFSR_TAPS (LFSR_TAPS),
        .LFSR_SEED (LFSR_SEED)
    ) arb_i (
        .clk     (clk),
        .rst     (rst),
        .take    (slot_start),
        .contend (contend),
        .win1    (win1)
    );

    swnode_decide #(
        .DEFLECT (DEFLECT)
    ) dec_i (
        .f0         (in0_frame),
        .a0         (in0_hdr[ADDR_SEL]),
        .f1         (in1_frame),
        .a1         (in1_hdr[ADDR_SEL]),
        .win1       (win1),
        .contend    (contend),
        .next_state (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst)             state_q <= ST_IDLE;
        else if (slot_start) state_q <= state_d;
        else if (slot_end)   state_q <= ST_IDLE;
    end

    assign in_msg[0]  = {in0_frame, in0_hdr, in0_data};
    assign in_msg[1]  = {in1_frame, in1_hdr, in1_data};
    assign out_ack[0] = out0_ack;
    assign out_ack[1] = out1_ack;

    swnode_xbar #(
        .MSG_W (MSG_W)
    ) xbar_i (
        .state   (state_q),
        .in_msg  (in_msg),
        .out_ack (out_ack),
        .out_msg (out_msg),
        .in_ack  (in_ack)
    );

    assign {out0_frame, out0_hdr, out0_data} = out_msg[0];
    assign {out1_frame, out1_hdr, out1_data} = out_msg[1];
    assign in0_ack = in_ack[0];
    assign in1_ack = in_ack[1];
    assign state_o = state_q;

endmodule

// File: rtl/swnode_chk.sv
module swnode_chk #(
    parameter bit DEFLECT = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       slot_start,
    input logic       slot_end,
    input logic       in0_frame,
    input logic       in1_frame,
    input logic       out0_frame,
    input logic       out1_frame,
    input logic       in0_ack,
    input logic       in1_ack,
    input logic [2:0] state_o
);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!slot_start && !slot_end) |=> $stable(state_o));

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (slot_end && !slot_start) |=> (state_o == 3'd0));

    assert_legal_R2: assert property (@(posedge clk) disable iff (rst)
        state_o != 3'd7);

    assert_empty_R12: assert property (@(posedge clk) disable iff (rst)
        (slot_start && !in0_frame && !in1_frame) |=> (state_o == 3'd0));

    assert_nolose_R5: assert property (@(posedge clk) disable iff (rst)
        (DEFLECT && slot_start && in0_frame && in1_frame)
            |=> (state_o == 3'd1 || state_o == 3'd2));

    assert_ackidle_R10: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd0) |-> (!in0_ack && !in1_ack));

    assert_dualout_R3: assert property (@(posedge clk) disable iff (rst)
        (out0_frame && out1_frame) |-> (state_o == 3'd1 || state_o == 3'd2));

endmodule

bind swnode_top swnode_chk #(.DEFLECT(DEFLECT)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .slot_start (slot_start),
    .slot_end   (slot_end),
    .in0_frame  (in0_frame),
    .in1_frame  (in1_frame),
    .out0_frame (out0_frame),
    .out1_frame (out1_frame),
    .in0_ack    (in0_ack),
    .in1_ack    (in1_ack),
    .state_o    (state_o)
);

// File: tb/swnode_top_tb_top.sv
module swnode_top_tb_top;
    import swnode_pkg::*;

    localparam int AW  = 3;
    localparam int SEL = 1;
    localparam int DW  = 16;
    localparam int MW  = 1 + AW + DW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slot_start = 1'b0, slot_end = 1'b0;
    logic f0 = 1'b0, f1 = 1'b0;
    logic [AW-1:0] h0 = '0, h1 = '0;
    logic [DW-1:0] d0 = '0, d1 = '0;
    logic ak0 = 1'b0, ak1 = 1'b0;

    logic [MW-1:0] o0 [3];
    logic [MW-1:0] o1 [3];
    logic          ia0 [3];
    logic          ia1 [3];
    logic [2:0]    st [3];

    int checks = 0;
    int errors = 0;
    bit turn_m = 1'b0;
    int rnd_w0 = 0, rnd_w1 = 0;
    logic [7:0] seen = '0;

    always #2 clk = ~clk;

    swnode_top #(.ADDR_W(AW), .ADDR_SEL(SEL), .DATA_W(DW), .DEFLECT(1'b0), .ARB(ARB_ALTERNATE)) dut_i (
        .clk(clk), .rst(rst), .slot_start(slot_start), .slot_end(slot_end),
        .in0_frame(f0), .in0_hdr(h0), .in0_data(d0),
        .in1_frame(f1), .in1_hdr(h1), .in1_data(d1),
        .out0_ack(ak0), .out1_ack(ak1),
        .out0_frame(o0[0][MW-1]), .out0_hdr(o0[0][MW-2:DW]), .out0_data(o0[0][DW-1:0]),
        .out1_frame(o1[0][MW-1]), .out1_hdr(o1[0][MW-2:DW]), .out1_data(o1[0][DW-1:0]),
        .in0_ack(ia0[0]), .in1_ack(ia1[0]), .state_o(st[0]));

    swnode_top #(.ADDR_W(AW), .ADDR_SEL(SEL), .DATA_W(DW), .DEFLECT(1'b1), .ARB(ARB_FIXED)) dut_d (
        .clk(clk), .rst(rst), .slot_start(slot_start), .slot_end(slot_end),
        .in0_frame(f0), .in0_hdr(h0), .in0_data(d0),
        .in1_frame(f1), .in1_hdr(h1), .in1_data(d1),
        .out0_ack(ak0), .out1_ack(ak1),
        .out0_frame(o0[1][MW-1]), .out0_hdr(o0[1][MW-2:DW]), .out0_data(o0[1][DW-1:0]),
        .out1_frame(o1[1][MW-1]), .out1_hdr(o1[1][MW-2:DW]), .out1_data(o1[1][DW-1:0]),
        .in0_ack(ia0[1]), .in1_ack(ia1[1]), .state_o(st[1]));

    swnode_top #(.ADDR_W(AW), .ADDR_SEL(SEL), .DATA_W(DW), .DEFLECT(1'b0), .ARB(ARB_RANDOM)) dut_r (
        .clk(clk), .rst(rst), .slot_start(slot_start), .slot_end(slot_end),
        .in0_frame(f0), .in0_hdr(h0), .in0_data(d0),
        .in1_frame(f1), .in1_hdr(h1), .in1_data(d1),
        .out0_ack(ak0), .out1_ack(ak1),
        .out0_frame(o0[2][MW-1]), .out0_hdr(o0[2][MW-2:DW]), .out0_data(o0[2][DW-1:0]),
        .out1_frame(o1[2][MW-1]), .out1_hdr(o1[2][MW-2:DW]), .out1_data(o1[2][DW-1:0]),
        .in0_ack(ia0[2]), .in1_ack(ia1[2]), .state_o(st[2]));

    // Expected state from the requirements (R3, R4, R5).
    function automatic logic [2:0] m_state(bit a, bit x0, bit b, bit x1, bit dfl, bit w1);
        bit wd;
        if (!a && !b) return 3'd0;
        if (a && !b)  return x0 ? 3'd4 : 3'd3;
        if (!a && b)  return x1 ? 3'd5 : 3'd6;
        if (x0 != x1) return x0 ? 3'd2 : 3'd1;
        wd = w1 ? x1 : x0;
        if (dfl) return (w1 ^ wd) ? 3'd2 : 3'd1;
        if (!w1) return wd ? 3'd4 : 3'd3;
        return wd ? 3'd5 : 3'd6;
    endfunction

    // Expected output bundle for a state (R2).
    function automatic logic [MW-1:0] m_out(logic [2:0] s, logic [MW-1:0] m0, logic [MW-1:0] m1, bit port);
        if (!port) return (s == 3'd1 || s == 3'd3) ? m0 : (s == 3'd2 || s == 3'd6) ? m1 : '0;
        return (s == 3'd1 || s == 3'd5) ? m1 : (s == 3'd2 || s == 3'd4) ? m0 : '0;
    endfunction

    // Expected returned acknowledgement (R10).
    function automatic bit m_ack(logic [2:0] s, bit inp, bit a0, bit a1);
        if (!inp) return (s == 3'd1 || s == 3'd3) ? a0 : (s == 3'd2 || s == 3'd4) ? a1 : 1'b0;
        return (s == 3'd1 || s == 3'd5) ? a1 : (s == 3'd2 || s == 3'd6) ? a0 : 1'b0;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Compare one copy's outputs against a given expected state.
    task automatic chk_dut(int k, logic [2:0] es, string req);
        logic [MW-1:0] m0, m1, e0, e1;
        bit ea0, ea1;
        m0 = {f0, h0, d0};
        m1 = {f1, h1, d1};
        e0 = m_out(es, m0, m1, 1'b0);
        e1 = m_out(es, m0, m1, 1'b1);
        ea0 = m_ack(es, 1'b0, ak0, ak1);
        ea1 = m_ack(es, 1'b1, ak0, ak1);
        chk(st[k] == es, req, 64'(st[k]), 64'(es));
        chk(o0[k] == e0, req, 64'(o0[k]), 64'(e0));
        chk(o1[k] == e1, req, 64'(o1[k]), 64'(e1));
        chk({ia0[k], ia1[k]} == {ea0, ea1}, "R10", 64'({ia0[k], ia1[k]}), 64'({ea0, ea1}));
    endtask

    task automatic slot(bit a, logic [AW-1:0] ha, logic [DW-1:0] da,
                        bit b, logic [AW-1:0] hb, logic [DW-1:0] db);
        bit contend;
        logic [2:0] e_alt, e_dfl, r0, r1, rs;
        @(negedge clk);
        f0 = a; h0 = ha; d0 = da;
        f1 = b; h1 = hb; d1 = db;
        ak0 = 1'($urandom); ak1 = 1'($urandom);
        slot_start = 1'b1;
        contend = a && b && (ha[SEL] == hb[SEL]);
        e_alt = m_state(a, ha[SEL], b, hb[SEL], 1'b0, turn_m);
        e_dfl = m_state(a, ha[SEL], b, hb[SEL], 1'b1, 1'b0);
        r0    = m_state(a, ha[SEL], b, hb[SEL], 1'b0, 1'b0);
        r1    = m_state(a, ha[SEL], b, hb[SEL], 1'b0, 1'b1);
        if (contend) turn_m = ~turn_m;
        @(negedge clk);
        slot_start = 1'b0;
        // R9: the state is visible one cycle after slot_start
        chk_dut(0, e_alt, contend ? "R6/R4" : "R3/R12");
        chk_dut(1, e_dfl, contend ? "R5/R7" : "R3");
        rs = st[2];
        chk(rs == r0 || rs == r1, "R8", 64'(rs), 64'(r0));
        if (rs == r0 || rs == r1) chk_dut(2, rs, "R8");
        if (contend && rs == r0) rnd_w0++;
        if (contend && rs == r1) rnd_w1++;
        seen[st[0]] = 1'b1;
        // R9: headers and frames change mid-slot, the state must not
        f0 = ~f0; f1 = ~f1;
        h0 = h0 ^ 3'b010; h1 = h1 ^ 3'b111;
        ak0 = ~ak0; ak1 = 1'($urandom);
        @(negedge clk);
        chk_dut(0, e_alt, "R9");
        chk_dut(1, e_dfl, "R9");
        chk(st[2] == rs, "R9", 64'(st[2]), 64'(rs));
        slot_end = 1'b1;
        @(negedge clk);
        slot_end = 1'b0;
        chk_dut(0, 3'd0, "R9");
        chk_dut(1, 3'd0, "R9");
        chk(st[2] == 3'd0, "R9", 64'(st[2]), 64'd0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            chk(st[k] == 3'd0 && o0[k] == '0 && o1[k] == '0 && !ia0[k] && !ia1[k],
                "R1", 64'(st[k]), 64'd0);
        end
        rst = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 3; k++) chk(st[k] == 3'd0, "R1", 64'(st[k]), 64'd0);

        // R12: empty slot
        slot(1'b0, 3'b010, 16'h1111, 1'b0, 3'b000, 16'h2222);
        // R3: single inputs toward each output
        slot(1'b1, 3'b000, 16'hA001, 1'b0, 3'b000, 16'h0000);
        slot(1'b1, 3'b010, 16'hA002, 1'b0, 3'b000, 16'h0000);
        slot(1'b0, 3'b000, 16'h0000, 1'b1, 3'b010, 16'hB001);
        slot(1'b0, 3'b000, 16'h0000, 1'b1, 3'b000, 16'hB002);
        // R3: no contention, straight and interchange
        slot(1'b1, 3'b000, 16'hC001, 1'b1, 3'b010, 16'hC002);
        slot(1'b1, 3'b010, 16'hC003, 1'b1, 3'b000, 16'hC004);
        // R6: four contentions, winner alternates; R7 fixed; R5 deflect
        slot(1'b1, 3'b000, 16'hD001, 1'b1, 3'b000, 16'hD002);
        slot(1'b1, 3'b010, 16'hD003, 1'b1, 3'b010, 16'hD004);
        slot(1'b1, 3'b010, 16'hD005, 1'b0, 3'b010, 16'hD006);
        slot(1'b1, 3'b010, 16'hD007, 1'b1, 3'b010, 16'hD008);
        slot(1'b1, 3'b000, 16'hD009, 1'b1, 3'b000, 16'hD00A);
        // R11: non-selected header bits differ, decision unchanged, bits pass through
        slot(1'b1, 3'b101, 16'hE001, 1'b0, 3'b111, 16'hE002);
        slot(1'b1, 3'b001, 16'hE003, 1'b1, 3'b100, 16'hE004);

        // R9: both strobes together load the new slot
        @(negedge clk);
        f0 = 1'b1; h0 = 3'b000; f1 = 1'b0; h1 = 3'b000;
        slot_start = 1'b1;
        @(negedge clk);
        f0 = 1'b0; f1 = 1'b1; h1 = 3'b010;
        slot_end = 1'b1;
        @(negedge clk);
        slot_start = 1'b0; slot_end = 1'b0;
        chk(st[0] == 3'd5, "R9", 64'(st[0]), 64'd5);
        seen[st[0]] = 1'b1;
        slot_end = 1'b1;
        @(negedge clk);
        slot_end = 1'b0;
        chk(st[0] == 3'd0, "R9", 64'(st[0]), 64'd0);

        // Random slots
        for (int n = 0; n < 400; n++) begin
            slot(($urandom % 4) != 0, 3'($urandom), 16'($urandom),
                 ($urandom % 4) != 0, 3'($urandom), 16'($urandom));
        end

        chk(rnd_w0 > 0 && rnd_w1 > 0, "R8", 64'(rnd_w1), 64'(1));
        chk(seen[6:0] == 7'h7F, "R2", 64'(seen), 64'h7F);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule